// File: doc/BRIEF.md
# Programmable Asynchronous Memory Bus Timer

This block runs read and write cycles on an external asynchronous memory (static RAM, flash or a memory-mapped peripheral). Each cycle has three phases whose lengths come from software: an address setup phase, an enable strobe phase and a hold phase that leaves room for bus turnaround. Reads and writes each have their own 12-bit timing word, so slow write timing does not slow down reads.

On the internal side a requester hands over one access at a time on a valid/ready channel that carries a word address, write data, a byte-lane mask and a read/write flag. The channel holds a request while `req_ready` is low, and a request moves only on a cycle where both `req_valid` and `req_ready` are high. Completion comes back as a one-cycle `rsp_valid` pulse with read data. There is no back-pressure on the response, so the requester must take it in the cycle it appears. Two speed-ups are built in. A single-entry posted write buffer releases the requester before the external write has run. A one-word sequential prefetch buffer lets a read of the next address finish without touching the bus.

On the external side the block drives an active-low chip select, read enable, write enable and byte-lane enables, plus the address and a bidirectional data bus.

Top module: `amem_timer`

## Requirements
- R1: Timing word layout, for both `cfg_rd` and `cfg_wr`: bits [1:0] set the setup count S, bits [7:2] set the strobe count T, bits [9:8] set the hold count H, and bit 10 selects half-cycle strobe. Bit 11 of `cfg_rd` enables prefetch. Bit 11 of `cfg_wr` disables the write buffer. When an access starts on the bus, `mem_cs_n` goes low and the enable strobes stay high for exactly S cycles. S=0 means the strobe begins in the first cycle of chip select. Address and byte lanes stay stable for as long as chip select is low.
- R2: The read or write enable is low for max(1,T) cycles. A programmed T of 0 still gives one strobe cycle.
- R3: After the strobe ends, `mem_cs_n` stays low for exactly H more cycles and then returns high.
- R4: Read data is sampled from the bus at the clock edge that ends the strobe. For a read served by the bus, `rsp_valid` pulses S+max(1,T)+H+1 cycles after the acceptance edge, carrying that data.
- R5: When half-cycle strobe is selected, the enable returns high at the falling clock edge in the middle of the last strobe cycle. The full strobe cycles before it are unchanged. When it is not selected, the enable never rises mid-cycle.
- R6: When the write buffer is enabled (`cfg_wr[11]`=0), an accepted write is acknowledged in the cycle right after the acceptance edge. The bus write follows, and `req_ready` stays low until it has completed, so a later read returns the written data.
- R7: When the write buffer is disabled, an accepted write starts on the bus in the cycle after acceptance, and `rsp_valid` follows S+max(1,T)+H+1 cycles after the acceptance edge.
- R8: With prefetch enabled, each completed read is followed by a full-word bus read of address+1. A later read of the prefetched address is acknowledged with its data in the cycle right after acceptance, with chip select high in that cycle.
- R9: A write to the prefetched address discards the prefetched word, so a following read of that address is served from the bus and returns the new data.
- R10: Read enable and write enable are never low together, and never low while chip select is high. The controller drives `mem_dq` only while chip select is low during a write.
- R11: `req_ready` is high only when no access is in flight and the write buffer is empty. After an access has been accepted that needs the bus, `req_ready` is low in the next cycle.
- R12: During an access `mem_be_n` is the inverse of the request's lane mask (bit i controls data bits 8i+7..8i). Prefetch reads use all lanes. Between accesses all lanes are high.
- R13: After reset, chip select, both enables and all byte lanes are high, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the half-cycle strobe uses its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rd | input | 12 | Read timing word and prefetch enable |
| cfg_wr | input | 12 | Write timing word and write-buffer disable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane mask, active high |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with the pulse of a read |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_re_n | output | 1 | Read enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte-lane enables, active low |
| mem_addr | output | ADDR_W | External address |
| mem_dq | inout | DATA_W | External data bus |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=16. That gives a sixteen-word memory model and a two-lane mask, so every setup and hold value from 0 to 3 can be combined with strobe counts 0, 1, 2 and 5, each in a write followed by a read. Cycle counts, latency and data for all of these are worked out arithmetically. The small address space also keeps the prefetch, invalidation, posted-write ordering and partial-lane cases short enough to check one by one, including the half-cycle strobe measured at the falling edge.

// File: rtl/amem_pkg.sv
package amem_pkg;
  localparam int SET_W = 2;
  localparam int STB_W = 6;
  localparam int HLD_W = 2;
  localparam int CFG_W = 12;

  typedef enum logic [1:0] {BS_IDLE, BS_SETUP, BS_STROBE, BS_HOLD} bus_st_t;
  typedef enum logic [2:0] {FS_IDLE, FS_RD, FS_WR, FS_DRAIN, FS_LAUNCH, FS_PF} front_st_t;

  typedef struct packed {
    logic             half;
    logic [HLD_W-1:0] hold;
    logic [STB_W-1:0] strobe;
    logic [SET_W-1:0] setup;
  } phase_t;

  function automatic phase_t to_phase(input logic [10:0] w);
    phase_t p;
    p.setup  = w[1:0];
    p.strobe = w[7:2];
    p.hold   = w[9:8];
    p.half   = w[10];
    return p;
  endfunction

  function automatic logic [STB_W-1:0] eff_strobe(input logic [STB_W-1:0] n);
    return (n == '0) ? STB_W'(1) : n;
  endfunction
endpackage

// File: rtl/amem_halfcut.sv
module amem_halfcut (
  input  logic clk,
  input  logic rst_n,
  input  logic last_cycle,
  input  logic half_en,
  output logic cut
);
  // Falling-edge flop: removes the enable for the second half of the final strobe cycle.
  always_ff @(negedge clk) begin
    if (!rst_n) cut <= 1'b0;
    else        cut <= last_cycle && half_en;
  end
endmodule

// File: rtl/amem_engine.sv
module amem_engine
  import amem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  input  phase_t            tm,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cs_n,
  output logic              re_n,
  output logic              we_n,
  output logic [BE_W-1:0]   be_n,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_o,
  input  logic [DATA_W-1:0] dq_i
);
  bus_st_t           st;
  logic [STB_W-1:0]  cnt;
  logic              wr_q;
  phase_t            tm_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic              cut;
  logic              strobe_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= BS_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      tm_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        BS_IDLE: if (start) begin
          wr_q    <= op_wr;
          tm_q    <= tm;
          addr_q  <= addr;
          wdata_q <= wdata;
          be_q    <= be;
          if (tm.setup != '0) begin
            st  <= BS_SETUP;
            cnt <= STB_W'(tm.setup) - STB_W'(1);
          end else begin
            st  <= BS_STROBE;
            cnt <= eff_strobe(tm.strobe) - STB_W'(1);
          end
        end
        BS_SETUP: begin
          if (cnt == '0) begin
            st  <= BS_STROBE;
            cnt <= eff_strobe(tm_q.strobe) - STB_W'(1);
          end else cnt <= cnt - STB_W'(1);
        end
        BS_STROBE: begin
          if (cnt == '0) begin
            if (!wr_q) rdata_q <= dq_i;
            if (tm_q.hold != '0) begin
              st  <= BS_HOLD;
              cnt <= STB_W'(tm_q.hold) - STB_W'(1);
            end else begin
              st     <= BS_IDLE;
              done_q <= 1'b1;
            end
          end else cnt <= cnt - STB_W'(1);
        end
        BS_HOLD: begin
          if (cnt == '0) begin
            st     <= BS_IDLE;
            done_q <= 1'b1;
          end else cnt <= cnt - STB_W'(1);
        end
        default: st <= BS_IDLE;
      endcase
    end
  end

  amem_halfcut u_halfcut (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_cycle (st == BS_STROBE && cnt == '0),
    .half_en    (tm_q.half),
    .cut        (cut)
  );

  assign strobe_on = (st == BS_STROBE) && !cut;
  assign cs_n   = (st == BS_IDLE);
  assign re_n   = !(strobe_on && !wr_q);
  assign we_n   = !(strobe_on && wr_q);
  assign be_n   = (st == BS_IDLE) ? '1 : ~be_q;
  assign addr_o = addr_q;
  assign dq_oe  = wr_q && (st != BS_IDLE);
  assign dq_o   = wdata_q;
  assign done   = done_q;
  assign rdata  = rdata_q;

  // R10: the two enables are mutually exclusive
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n) re_n || we_n);
  // R10: an enable is only active inside chip select
  p_strobe_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!re_n || !we_n) |-> !cs_n);
  // R1: address and lanes hold still while chip select stays low
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(addr_o) && $stable(be_n)));
  // R1: a nonzero setup keeps the strobes off in the first chip-select cycle
  p_setup_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && tm_q.setup != '0) |-> (re_n && we_n));
  // R4: completion from the engine is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

// File: rtl/amem_timer.sv
module amem_timer
  import amem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       cfg_rd,
  input  logic [11:0]       cfg_wr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_re_n,
  output logic              mem_we_n,
  output logic [BE_W-1:0]   mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);
  front_st_t         fst;
  logic              wbuf_v;
  logic [ADDR_W-1:0] wbuf_addr;
  logic [DATA_W-1:0] wbuf_data;
  logic [BE_W-1:0]   wbuf_be;
  logic              pf_v;
  logic [ADDR_W-1:0] pf_addr;
  logic [DATA_W-1:0] pf_data;
  logic [ADDR_W-1:0] next_addr;
  logic              rsp_v_q;
  logic [DATA_W-1:0] rsp_d_q;

  phase_t rd_tm, wr_tm;
  logic   pf_en, wb_dis, accept, hit;

  logic              e_start, e_wr, e_done, e_oe;
  logic [ADDR_W-1:0] e_addr;
  logic [DATA_W-1:0] e_data, e_rdata, e_dq_o;
  logic [BE_W-1:0]   e_be;
  phase_t            e_tm;

  assign rd_tm     = to_phase(cfg_rd[10:0]);
  assign wr_tm     = to_phase(cfg_wr[10:0]);
  assign pf_en     = cfg_rd[11];
  assign wb_dis    = cfg_wr[11];
  assign req_ready = (fst == FS_IDLE) && !wbuf_v;
  assign accept    = req_valid && req_ready;
  assign hit       = pf_v && (pf_addr == req_addr);

  always_comb begin
    e_start = 1'b0;
    e_wr    = req_write;
    e_addr  = req_addr;
    e_data  = req_wdata;
    e_be    = req_be;
    if (fst == FS_IDLE && wbuf_v) begin
      e_start = 1'b1;
      e_wr    = 1'b1;
      e_addr  = wbuf_addr;
      e_data  = wbuf_data;
      e_be    = wbuf_be;
    end else if (fst == FS_LAUNCH) begin
      e_start = 1'b1;
      e_wr    = 1'b0;
      e_addr  = next_addr;
      e_be    = '1;
    end else if (accept) begin
      e_start = req_write ? wb_dis : !hit;
    end
    e_tm = e_wr ? wr_tm : rd_tm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fst       <= FS_IDLE;
      wbuf_v    <= 1'b0;
      wbuf_addr <= '0;
      wbuf_data <= '0;
      wbuf_be   <= '0;
      pf_v      <= 1'b0;
      pf_addr   <= '0;
      pf_data   <= '0;
      next_addr <= '0;
      rsp_v_q   <= 1'b0;
      rsp_d_q   <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      case (fst)
        FS_IDLE: begin
          if (wbuf_v) fst <= FS_DRAIN;
          else if (accept) begin
            if (req_write) begin
              if (hit) pf_v <= 1'b0;
              if (wb_dis) fst <= FS_WR;
              else begin
                wbuf_v    <= 1'b1;
                wbuf_addr <= req_addr;
                wbuf_data <= req_wdata;
                wbuf_be   <= req_be;
                rsp_v_q   <= 1'b1;
              end
            end else begin
              next_addr <= req_addr + ADDR_W'(1);
              if (hit) begin
                rsp_v_q <= 1'b1;
                rsp_d_q <= pf_data;
                fst     <= pf_en ? FS_LAUNCH : FS_IDLE;
              end else fst <= FS_RD;
            end
          end
        end
        FS_RD: if (e_done) begin
          rsp_v_q <= 1'b1;
          rsp_d_q <= e_rdata;
          fst     <= pf_en ? FS_LAUNCH : FS_IDLE;
        end
        FS_WR: if (e_done) begin
          rsp_v_q <= 1'b1;
          fst     <= FS_IDLE;
        end
        FS_DRAIN: if (e_done) begin
          wbuf_v <= 1'b0;
          fst    <= FS_IDLE;
        end
        FS_LAUNCH: begin
          pf_v <= 1'b0;
          fst  <= FS_PF;
        end
        FS_PF: if (e_done) begin
          pf_v    <= 1'b1;
          pf_addr <= next_addr;
          pf_data <= e_rdata;
          fst     <= FS_IDLE;
        end
        default: fst <= FS_IDLE;
      endcase
    end
  end

  amem_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (e_start),
    .op_wr  (e_wr),
    .addr   (e_addr),
    .wdata  (e_data),
    .be     (e_be),
    .tm     (e_tm),
    .done   (e_done),
    .rdata  (e_rdata),
    .cs_n   (mem_cs_n),
    .re_n   (mem_re_n),
    .we_n   (mem_we_n),
    .be_n   (mem_be_n),
    .addr_o (mem_addr),
    .dq_oe  (e_oe),
    .dq_o   (e_dq_o),
    .dq_i   (mem_dq)
  );

  assign mem_dq    = e_oe ? e_dq_o : 'z;
  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_d_q;

  // R11: the requester is only let in while the external bus is quiet
  p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n);
  // R10: the controller drives the bus only inside a write's chip select
  p_dq_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    e_oe |-> (!mem_cs_n && mem_re_n));
  // R6: a posted write is acknowledged on the next cycle
  p_posted_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && !wb_dis) |=> rsp_valid);
  // R8: a read of the prefetched word completes next cycle without the bus
  p_hit_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && hit) |=> (rsp_valid && mem_cs_n));
endmodule

// File: tb/amem_timer_bench.sv
`timescale 1ns/100ps
module amem_timer_bench;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   cfg_rd = '0;
  logic [11:0]   cfg_wr = '0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_cs_n, mem_re_n, mem_we_n;
  logic [1:0]    mem_be_n;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;

  amem_timer #(.ADDR_W(AW), .DATA_W(DW)) u_amem_timer (
    .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, rsp_count = 0, last_rsp_cyc = 0, strobe_err = 0;
  int n_set, n_stb, n_hld, n_cut, m_set, m_stb, m_hld, m_cut;
  logic act = 1'b0, seen = 1'b0, rd_phase = 1'b0, stb1;
  logic [1:0]    m_be;
  logic [DW-1:0] last_rdata;
  logic [DW-1:0] bmem [16];
  int g_acc, g_lat;
  logic g_csacc, g_rdy_next;

  assign mem_dq = (!mem_cs_n && rd_phase) ? bmem[mem_addr] : 16'bz;

  // Monitor and memory model: samples 1 ns after each rising edge, then at mid-low phase.
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rsp_valid) begin rsp_count++; last_rsp_cyc = cyc; last_rdata = rsp_rdata; end
    if (!mem_re_n && !mem_we_n) strobe_err++;
    if (mem_cs_n && (!mem_re_n || !mem_we_n)) strobe_err++;
    stb1 = !mem_re_n || !mem_we_n;
    if (!mem_cs_n) begin
      if (!act) begin act = 1'b1; seen = 1'b0; n_set = 0; n_stb = 0; n_hld = 0; n_cut = 0; end
      if (stb1) begin
        n_stb++; seen = 1'b1; m_be = mem_be_n;
        if (!mem_re_n) rd_phase = 1'b1;
        if (!mem_we_n)
          for (int i = 0; i < 2; i++) if (!mem_be_n[i]) bmem[mem_addr][i*8 +: 8] = mem_dq[i*8 +: 8];
      end else if (!seen) n_set++;
      else n_hld++;
    end else begin
      if (act) begin act = 1'b0; m_set = n_set; m_stb = n_stb; m_hld = n_hld; m_cut = n_cut; end
      rd_phase = 1'b0;
    end
    #2.5;
    if (act && stb1 && mem_re_n && mem_we_n) n_cut++;
  end

  task automatic chk(input string req, input int act_v, input int exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    int base;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    base = rsp_count;
    @(posedge clk); #2;
    g_acc = cyc; g_csacc = mem_cs_n;
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #2;
    g_rdy_next = req_ready;
    wait (rsp_count != base);
    g_lat = last_rsp_cyc - g_acc;
    @(negedge clk);
    while (!(req_ready && mem_cs_n)) @(negedge clk);
  endtask

  function automatic logic [11:0] mk(input bit top, input bit half, input int h, input int t, input int s);
    return {top, half, 2'(h), 6'(t), 2'(s)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tl [4] = '{0, 1, 2, 5};
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: reset state
    chk("R13 cs", mem_cs_n, 1); chk("R13 re", mem_re_n, 1); chk("R13 we", mem_we_n, 1);
    chk("R13 be", mem_be_n, 3); chk("R13 ready", req_ready, 1); chk("R13 rsp", rsp_valid, 0);

    // R1 R2 R3 R4 R7: sweep of setup, strobe and hold, unbuffered writes and plain reads
    for (int s = 0; s < 4; s++)
      for (int h = 0; h < 4; h++)
        for (int k = 0; k < 4; k++) begin
          int t = tl[k];
          int eff = (t == 0) ? 1 : t;
          logic [AW-1:0] a = AW'(s * 4 + h);
          logic [DW-1:0] d = 16'h5A00 ^ DW'(s * 256 + h * 16 + t + k * 4096);
          cfg_wr = mk(1'b1, 1'b0, h, t, s);
          cfg_rd = mk(1'b0, 1'b0, h, t, s);
          xfer(1'b1, a, d, 2'b11);
          chk("R1 write setup", m_set, s); chk("R2 write strobe", m_stb, eff);
          chk("R3 write hold", m_hld, h); chk("R7 write latency", g_lat, s + eff + h + 1);
          chk("R5 write no cut", m_cut, 0); chk("R11 ready low", g_rdy_next, 0);
          xfer(1'b0, a, '0, 2'b11);
          chk("R1 read setup", m_set, s); chk("R2 read strobe", m_stb, eff);
          chk("R3 read hold", m_hld, h); chk("R4 read latency", g_lat, s + eff + h + 1);
          chk("R4 read data", last_rdata, d); chk("R1 cs in cycle after accept", g_csacc, 0);
        end

    // R5: half-cycle strobe on both directions
    for (int k = 0; k < 2; k++) begin
      int t = (k == 0) ? 0 : 3;
      int eff = (t == 0) ? 1 : t;
      cfg_wr = mk(1'b1, 1'b1, 1, t, 1);
      cfg_rd = mk(1'b0, 1'b1, 1, t, 1);
      xfer(1'b1, 4'd12, 16'hC3A5 + DW'(k), 2'b11);
      chk("R5 write cut", m_cut, 1); chk("R5 write strobe", m_stb, eff);
      xfer(1'b0, 4'd12, '0, 2'b11);
      chk("R5 read cut", m_cut, 1); chk("R5 read strobe", m_stb, eff);
      chk("R5 read data", last_rdata, 16'hC3A5 + DW'(k));
    end

    // R6: posted write, ordering against the following read
    cfg_wr = mk(1'b0, 1'b0, 1, 6, 2);
    cfg_rd = mk(1'b0, 1'b0, 1, 2, 1);
    xfer(1'b1, 4'd3, 16'h1234, 2'b11);
    chk("R6 posted ack", g_lat, 0); chk("R6 cs high at ack", g_csacc, 1);
    chk("R11 ready low while draining", g_rdy_next, 0); chk("R6 drained strobe", m_stb, 6);
    xfer(1'b0, 4'd3, '0, 2'b11);
    chk("R6 read after posted", last_rdata, 16'h1234);

    // R12: partial lanes
    cfg_wr = mk(1'b1, 1'b0, 0, 1, 0);
    xfer(1'b1, 4'd9, 16'h1111, 2'b11);
    xfer(1'b1, 4'd9, 16'hABCD, 2'b10);
    chk("R12 lane pins", m_be, 2'b01);
    xfer(1'b0, 4'd9, '0, 2'b11);
    chk("R12 merged data", last_rdata, 16'hAB11);

    // R8 R9: prefetch hit and invalidation
    xfer(1'b1, 4'd5, 16'h0505, 2'b11);
    xfer(1'b1, 4'd6, 16'h0606, 2'b11);
    xfer(1'b1, 4'd7, 16'h0707, 2'b11);
    cfg_rd = mk(1'b1, 1'b0, 1, 2, 1);
    xfer(1'b0, 4'd5, '0, 2'b11);
    chk("R8 first read data", last_rdata, 16'h0505);
    chk("R12 prefetch lanes", m_be, 2'b00);
    xfer(1'b0, 4'd6, '0, 2'b11);
    chk("R8 hit latency", g_lat, 0); chk("R8 hit no bus", g_csacc, 1);
    chk("R8 hit data", last_rdata, 16'h0606);
    cfg_wr = mk(1'b0, 1'b0, 0, 1, 0);
    xfer(1'b1, 4'd7, 16'h7777, 2'b11);
    xfer(1'b0, 4'd7, '0, 2'b11);
    chk("R9 goes to bus", g_lat, 1 + 2 + 1 + 1);
    chk("R9 new data", last_rdata, 16'h7777);

    // R10: enables exclusive and inside chip select over the whole run
    chk("R10 strobe overlap", strobe_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule